// File: doc/BRIEF.md
# Video-RAM Access Clock Stretcher

This block sits between a processor and a video slot sequencer that owns a shared video memory. The two run from separate, unrelated oscillators. When the processor starts a memory cycle into the video-mapped region, or an I/O cycle to the video controller's port group, the block pulls the processor clock enable low. It keeps it low until the sequencer's processor window, brought safely into the processor domain, comes around. It then grants the video memory port for a fixed window, adds a fixed tail wait, and lets the processor run again.

The block is clocked at twice the processor rate, so each tick is one processor half-cycle. The stall length therefore depends on where the access falls relative to the slot phase, and it moves in half-cycle steps. A small wait-state control register sits on I/O port 0xBF. It switches the ordinary memory wait states on or off, and it never touches the video stretching.

Top module: `vram_clk_stretch`

## Requirements
- R1: After reset, `cpu_clk_en` is 1, `vram_grant` is 0 and `mem_wait_en` is 1.
- R2: A rising memory strobe (`cpu_mreq`) while `vram_sel` is 1 drives `cpu_clk_en` low from the tick after the first edge that sees the strobe.
- R3: A rising I/O strobe (`cpu_iorq`) with `cpu_port[7:4]` equal to 4'h8 (ports 0x80 through 0x8F) is stretched in the same way as R2.
- R4: Memory cycles with `vram_sel` at 0, and I/O cycles to any port outside 0x80–0x8F, leave `cpu_clk_en` at 1 and `vram_grant` at 0.
- R5: `vid_win` passes two synchronizer flops before it is used. With the window already settled high, the grant starts one tick after the access is seen. If the window rises before edge W (W ≥ 0) counted from the access edge, the grant starts after edge max(1, W+2).
- R6: Each stretched access produces exactly one grant pulse, GRANT_HC ticks long (default 2). `cpu_clk_en` is 0 throughout the grant.
- R7: After the grant ends, `cpu_clk_en` stays 0 for EXTRA_HC more ticks (default 1, one half-cycle), then returns to 1. The total number of low ticks is max(1, W+2) + GRANT_HC + EXTRA_HC.
- R8: Once released, `cpu_clk_en` stays 1 while the strobe is still held. A new stretch needs the strobe to fall and rise again.
- R9: An I/O write (`cpu_iorq` and `cpu_wr`) to port 0xBF loads `cpu_wdata`. `mem_wait_en` becomes 0 when bits [3:2] of the loaded value are both 1 (for example 0x0C), and 1 otherwise. The write itself is never stretched.
- R10: With ordinary wait states disabled by R9, video accesses are still stretched exactly as in R7.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_hc | input | 1 | Half-cycle clock, twice the processor rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_port | input | 8 | Low byte of the processor address, used as the I/O port number |
| cpu_mreq | input | 1 | Memory cycle strobe |
| cpu_iorq | input | 1 | I/O cycle strobe |
| cpu_wr | input | 1 | Write cycle indicator |
| cpu_wdata | input | 8 | Processor write data |
| vram_sel | input | 1 | Memory region select: 1 when the address maps to video RAM |
| vid_win | input | 1 | Processor-window flag from the video sequencer (other clock domain) |
| cpu_clk_en | output | 1 | Processor clock enable; 0 stalls the processor |
| vram_grant | output | 1 | Grant of the video memory port to the processor |
| mem_wait_en | output | 1 | Ordinary memory wait states enabled |

## Verification
The assertions assume the processor keeps its strobe high until `cpu_clk_en` returns. They also assume that a synchronized window, once high, stays high for at least the grant length, since the grant is counted and does not follow the window. The bench drives every input on the falling edge. It holds the strobe across the whole stall, keeps `vid_win` high for many ticks once raised, and drops both strobe and window between accesses. Stall lengths are measured for a settled window and for windows that arrive at several delays after the request.

// File: rtl/vs_pkg.sv
package vs_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_SEEK  = 3'd1,
    ST_GRANT = 3'd2,
    ST_TAIL  = 3'd3,
    ST_DONE  = 3'd4
  } stretch_st_e;

  function automatic int unsigned cnt_width(input int unsigned a, input int unsigned b);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m < 2) ? 1 : $clog2(m + 1);
  endfunction
endpackage

// File: rtl/vs_reset_sync.sv
module vs_reset_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb chain_d = {chain_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/vs_sync.sv
module vs_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] stg_q;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      logic nxt;
      if (g == 0) begin : g_first
        always_comb nxt = d;
      end else begin : g_rest
        always_comb nxt = stg_q[g-1];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q[g] <= 1'b0;
        else        stg_q[g] <= nxt;
      end
    end
  endgenerate

  assign q = stg_q[STAGES-1];
endmodule

// File: rtl/vs_decode.sv
module vs_decode #(
  parameter logic [3:0] VID_PORT_HI = 4'h8,
  parameter logic [7:0] WS_PORT     = 8'hBF
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] cpu_port,
  input  logic       cpu_mreq,
  input  logic       cpu_iorq,
  input  logic       cpu_wr,
  input  logic       vram_sel,
  output logic       acc_start,
  output logic       ws_write
);
  logic hit, hit_q;
  logic ws_hit, ws_q;

  always_comb begin
    hit    = (cpu_mreq & vram_sel) | (cpu_iorq & (cpu_port[7:4] == VID_PORT_HI));
    ws_hit = cpu_iorq & cpu_wr & (cpu_port == WS_PORT);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hit_q <= 1'b0;
      ws_q  <= 1'b0;
    end else begin
      hit_q <= hit;
      ws_q  <= ws_hit;
    end
  end

  assign acc_start = hit & ~hit_q;
  assign ws_write  = ws_hit & ~ws_q;
endmodule

// File: rtl/vs_waitreg.sv
module vs_waitreg #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ws_write,
  input  logic [DATA_W-1:0] wdata,
  output logic              mem_wait_en
);
  logic [DATA_W-1:0] ws_q, ws_d;

  always_comb ws_d = ws_write ? wdata : ws_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ws_q <= '0;
    else        ws_q <= ws_d;
  end

  assign mem_wait_en = ~(ws_q[3] & ws_q[2]);

  // R9: the wait-state enable moves only after a port write
  assert_ws_only_on_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mem_wait_en) |-> $past(ws_write));
endmodule

// File: rtl/vs_stretch_fsm.sv
module vs_stretch_fsm
  import vs_pkg::*;
#(
  parameter int unsigned GRANT_HC = 2,
  parameter int unsigned EXTRA_HC = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic acc_start,
  input  logic acc_held,
  input  logic win_sync,
  output logic cpu_clk_en,
  output logic vram_grant
);
  localparam int unsigned CNT_W = cnt_width(GRANT_HC, EXTRA_HC);
  localparam logic [CNT_W-1:0] GRANT_LAST = CNT_W'(GRANT_HC - 1);
  localparam logic [CNT_W-1:0] EXTRA_LAST = CNT_W'(EXTRA_HC - 1);

  stretch_st_e st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    unique case (st_q)
      ST_IDLE:  if (acc_start) st_d = ST_SEEK;
      ST_SEEK:  if (win_sync) begin
                  st_d  = ST_GRANT;
                  cnt_d = GRANT_LAST;
                end
      ST_GRANT: if (cnt_q == '0) begin
                  st_d  = ST_TAIL;
                  cnt_d = EXTRA_LAST;
                end else begin
                  cnt_d = cnt_q - 1'b1;
                end
      ST_TAIL:  if (cnt_q == '0) st_d = ST_DONE;
                else             cnt_d = cnt_q - 1'b1;
      ST_DONE:  if (!acc_held) st_d = ST_IDLE;
      default:  st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
    end
  end

  assign cpu_clk_en = (st_q == ST_IDLE) || (st_q == ST_DONE);
  assign vram_grant = (st_q == ST_GRANT);

  // independent run-length counter for the grant pulse
  logic [CNT_W:0] glen_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          glen_q <= '0;
    else if (vram_grant) glen_q <= glen_q + 1'b1;
    else                 glen_q <= '0;
  end

  assert_grant_stalls_R6: assert property (@(posedge clk) disable iff (!rst_n)
    vram_grant |-> !cpu_clk_en);
  assert_grant_len_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(vram_grant) |-> (glen_q == (CNT_W+1)'(GRANT_HC)));
  assert_grant_in_window_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(vram_grant) |-> $past(win_sync));
  assert_tail_wait_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(vram_grant) |-> !cpu_clk_en);
endmodule

// File: rtl/vram_clk_stretch.sv
module vram_clk_stretch #(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned GRANT_HC    = 2,
  parameter int unsigned EXTRA_HC    = 1,
  parameter logic [3:0]  VID_PORT_HI = 4'h8,
  parameter logic [7:0]  WS_PORT     = 8'hBF
) (
  input  logic       clk_hc,
  input  logic       rst_n,
  input  logic [7:0] cpu_port,
  input  logic       cpu_mreq,
  input  logic       cpu_iorq,
  input  logic       cpu_wr,
  input  logic [7:0] cpu_wdata,
  input  logic       vram_sel,
  input  logic       vid_win,
  output logic       cpu_clk_en,
  output logic       vram_grant,
  output logic       mem_wait_en
);
  logic rst_n_i;
  logic acc_start, ws_write, win_sync, acc_held;

  vs_reset_sync #(.STAGES(2)) i_rst (
    .clk(clk_hc), .rst_n(rst_n), .rst_n_sync(rst_n_i)
  );

  vs_sync #(.STAGES(SYNC_STAGES)) i_win_sync (
    .clk(clk_hc), .rst_n(rst_n_i), .d(vid_win), .q(win_sync)
  );

  vs_decode #(.VID_PORT_HI(VID_PORT_HI), .WS_PORT(WS_PORT)) i_dec (
    .clk(clk_hc), .rst_n(rst_n_i), .cpu_port(cpu_port), .cpu_mreq(cpu_mreq),
    .cpu_iorq(cpu_iorq), .cpu_wr(cpu_wr), .vram_sel(vram_sel),
    .acc_start(acc_start), .ws_write(ws_write)
  );

  assign acc_held = cpu_mreq | cpu_iorq;

  vs_waitreg #(.DATA_W(8)) i_ws (
    .clk(clk_hc), .rst_n(rst_n_i), .ws_write(ws_write), .wdata(cpu_wdata),
    .mem_wait_en(mem_wait_en)
  );

  vs_stretch_fsm #(.GRANT_HC(GRANT_HC), .EXTRA_HC(EXTRA_HC)) i_fsm (
    .clk(clk_hc), .rst_n(rst_n_i), .acc_start(acc_start), .acc_held(acc_held),
    .win_sync(win_sync), .cpu_clk_en(cpu_clk_en), .vram_grant(vram_grant)
  );

  // R4: the processor is only ever stalled by a decoded video access
  assert_no_spurious_stall_R4: assert property (@(posedge clk_hc) disable iff (!rst_n_i)
    $fell(cpu_clk_en) |-> $past(acc_start));
  // R8: once free, the clock enable stays up while the strobe is held
  assert_hold_release_R8: assert property (@(posedge clk_hc) disable iff (!rst_n_i)
    (cpu_clk_en && acc_held && !acc_start) |=> cpu_clk_en);
endmodule

// File: tb/test_vram_clk_stretch.sv
module test_vram_clk_stretch;
  localparam int GRANT_HC = 2;
  localparam int EXTRA_HC = 1;

  logic       clk_hc = 1'b0;
  logic       rst_n;
  logic [7:0] cpu_port;
  logic       cpu_mreq, cpu_iorq, cpu_wr, vram_sel, vid_win;
  logic [7:0] cpu_wdata;
  logic       cpu_clk_en, vram_grant, mem_wait_en;

  int checks = 0;
  int fails  = 0;

  vram_clk_stretch i_vram_clk_stretch (
    .clk_hc(clk_hc), .rst_n(rst_n), .cpu_port(cpu_port), .cpu_mreq(cpu_mreq),
    .cpu_iorq(cpu_iorq), .cpu_wr(cpu_wr), .cpu_wdata(cpu_wdata), .vram_sel(vram_sel),
    .vid_win(vid_win), .cpu_clk_en(cpu_clk_en), .vram_grant(vram_grant),
    .mem_wait_en(mem_wait_en)
  );

  always #10 clk_hc = ~clk_hc;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic idle_bus();
    cpu_mreq = 0; cpu_iorq = 0; cpu_wr = 0; vram_sel = 0;
    cpu_port = 8'h00; cpu_wdata = 8'h00;
  endtask

  // Runs one access. win_at < 0: window already settled high.
  // Otherwise window raised at the negedge before edge win_at.
  task automatic access(input string req, input bit io, input logic [7:0] port,
                        input bit vsel, input int win_at, input int exp_low);
    int low = 0, gr = 0, rises = 0;
    bit prev_g = 0;
    if (win_at < 0) begin
      vid_win = 1;
      repeat (4) @(negedge clk_hc);
    end else vid_win = 0;
    cpu_port = port; vram_sel = vsel;
    if (io) cpu_iorq = 1; else cpu_mreq = 1;
    for (int k = 0; k < 40; k++) begin
      if (k == win_at) vid_win = 1;
      @(negedge clk_hc);
      if (!cpu_clk_en) low++;
      if (vram_grant) gr++;
      if (vram_grant && !prev_g) rises++;
      prev_g = vram_grant;
      if (exp_low == 0 && k == 6) break;
      if (low > 0 && cpu_clk_en) break;
    end
    check(req, low, exp_low);
    if (exp_low > 0) begin
      check("R6 grant length", gr, GRANT_HC);
      check("R6 grant pulses", rises, 1);
      repeat (3) begin
        @(negedge clk_hc);
        check("R8 held after release", int'(cpu_clk_en), 1);
      end
    end else begin
      check("R4 no grant", gr, 0);
    end
    idle_bus();
    vid_win = 0;
    repeat (3) @(negedge clk_hc);
  endtask

  task automatic t_reset();
    check("R1 clk_en", int'(cpu_clk_en), 1);
    check("R1 grant", int'(vram_grant), 0);
    check("R1 mem_wait_en", int'(mem_wait_en), 1);
  endtask

  task automatic t_vram_mem();
    access("R2 settled window", 0, 8'h00, 1, -1, 1 + GRANT_HC + EXTRA_HC);
    access("R5 window at edge 0", 0, 8'h00, 1, 0, 2 + GRANT_HC + EXTRA_HC);
    access("R5 window at edge 3", 0, 8'h00, 1, 3, 5 + GRANT_HC + EXTRA_HC);
    access("R7 window at edge 6", 0, 8'h00, 1, 6, 8 + GRANT_HC + EXTRA_HC);
  endtask

  task automatic t_vid_ports();
    access("R3 port 0x80", 1, 8'h80, 0, -1, 1 + GRANT_HC + EXTRA_HC);
    access("R3 port 0x8F", 1, 8'h8F, 0, 1, 3 + GRANT_HC + EXTRA_HC);
  endtask

  task automatic t_passthrough();
    access("R4 mem outside vram", 0, 8'h00, 0, -1, 0);
    access("R4 port 0x7F", 1, 8'h7F, 0, -1, 0);
    access("R4 port 0x90", 1, 8'h90, 0, -1, 0);
  endtask

  task automatic ws_write(input logic [7:0] d, input int exp);
    int low = 0;
    cpu_port = 8'hBF; cpu_wdata = d; cpu_iorq = 1; cpu_wr = 1;
    repeat (3) begin
      @(negedge clk_hc);
      if (!cpu_clk_en) low++;
    end
    check("R9 write not stretched", low, 0);
    check("R9 mem_wait_en", int'(mem_wait_en), exp);
    idle_bus();
    repeat (2) @(negedge clk_hc);
  endtask

  task automatic t_waitreg();
    ws_write(8'h0C, 0);
    access("R10 stretch with waits off", 0, 8'h00, 1, -1, 1 + GRANT_HC + EXTRA_HC);
    ws_write(8'h08, 1);
    ws_write(8'hFF, 0);
    ws_write(8'h04, 1);
  endtask

  initial begin
    idle_bus();
    vid_win = 0;
    rst_n = 0;
    repeat (3) @(negedge clk_hc);
    rst_n = 1;
    repeat (4) @(negedge clk_hc);
    t_reset();
    t_vram_mem();
    t_vid_ports();
    t_passthrough();
    t_waitreg();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_hc);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule